// File: doc/BRIEF.md
# Ambient-Light Auto-Brightness Controller

This block sets the brightness of a bank of LEDs from the ambient light level. A free-running request timer starts a serial read of an external light-sensor converter at a fixed interval. The block is the bus master: it drives an active-low chip select and a serial clock, and it collects a 16-bit frame from the sensor's data line. Eight of those bits carry the light level. When a frame completes, the 8-bit level is loaded as the duty setting of a 256-step PWM generator. A prescaler paces the PWM steps, and the PWM output drives the LEDs. More light gives a longer on-time per PWM period.

The reset comes from a mechanical switch. It is synchronised and debounced inside the block, and the clean level then resets every other register. The debouncer has no reset of its own. After power-up, the switch must be held pressed for at least DEBOUNCE_CLKS + 2^⌈log2(DEBOUNCE_CLKS+1)⌉ + 2 cycles before the rest of the block can be trusted.

Two parameter rules apply. REQ_PERIOD must exceed 2·HALF_CLKS·FRAME_BITS + 1. HALF_CLKS must be at least 3, so that the two-stage synchroniser on the data line settles before the sampling edge.

Top module: `auto_bright_ctrl`

## Requirements
- R1: The reset switch is active high. The internal reset follows the switch only after the synchronised switch level has differed from the current reset level on DEBOUNCE_CLKS consecutive clock edges. The reset changes at the (DEBOUNCE_CLKS+2)th edge after the switch changes. A press or release that lasts fewer edges has no effect.
- R2: While the internal reset is asserted, spi_cs_n is 1, spi_sclk is 1 and led_out is 0.
- R3: Counting edges after the reset is released, spi_cs_n goes low at edge REQ_PERIOD+1, and then every REQ_PERIOD edges after that.
- R4: A frame keeps spi_cs_n low for 2·HALF_CLKS·FRAME_BITS edges. spi_sclk is high when spi_cs_n falls. It toggles every HALF_CLKS edges, starting with a falling edge. Its final rising edge falls on the same edge at which spi_cs_n returns high. Between frames both lines stay high.
- R5: The sample is built MSB first from spi_miso as seen at rising spi_sclk edges LEAD_BITS+1 through LEAD_BITS+8 of a frame (4th to 11th by default). The bits at all other rising edges are ignored.
- R6: The duty setting changes only at the edge one cycle after spi_cs_n rises at the end of a frame. It takes that frame's sample.
- R7: The PWM step counter runs 0..255 from reset and advances once every PWM_PRESCALE cycles. led_out is 1 exactly while the step is below the duty value. A duty of 0 keeps the LEDs dark, and a duty of d gives d·PWM_PRESCALE on-cycles in every 256·PWM_PRESCALE cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_sw | input | 1 | Raw reset switch, active high, asynchronous and bouncy |
| spi_cs_n | output | 1 | Sensor chip select, active low |
| spi_sclk | output | 1 | Serial clock to the sensor, idle high |
| spi_miso | input | 1 | Serial data from the sensor, asynchronous to clk |
| led_out | output | 1 | PWM drive for the LEDs |

## Verification
The bench checks that ones driven on the lead-in and trailing bit positions never reach the duty value. A design that samples one sclk edge early or late shows a wrong on-time on exactly those frames. It checks the boundary samples 0x00, 0x01, 0x80 and 0xFF. A design with a less-or-equal comparator, or with a 255-step period, lights a dark LED or miscounts full brightness. It applies a switch press one edge shorter than the debounce window, then one exactly as long. A debouncer that counts one short would reset on the glitch, and one that counts one long would miss the frame timing that follows. Frame start times and duty load times are compared on every cycle, so a request counter or a load that is off by one shows up at once.

// File: rtl/abc_pkg.sv
package abc_pkg;

    localparam int SAMPLE_W = 8;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef enum logic {
        RD_IDLE  = 1'b0,
        RD_SHIFT = 1'b1
    } rd_state_e;

    typedef struct packed {
        logic cs_n;
        logic sclk;
    } spi_pins_t;

    // True when the zero-based rising-edge index lies inside the data window.
    function automatic logic in_window(input int rise_idx, input int lead);
        return (rise_idx >= lead) && (rise_idx < lead + SAMPLE_W);
    endfunction

endpackage

// File: rtl/abc_debounce.sv
module abc_debounce #(
    parameter int STABLE_CLKS = 8
) (
    input  logic clk,
    input  logic raw_in,
    output logic clean_out
);
    localparam int CW = $clog2(STABLE_CLKS + 1);

    logic          sync_a;
    logic          sync_b;
    logic          level_q;
    logic [CW-1:0] run_q;

    // No reset here: this block produces the reset for everything else.
    always_ff @(posedge clk) begin
        sync_a <= raw_in;
        sync_b <= sync_a;
        if (sync_b != level_q) begin
            if (run_q == CW'(STABLE_CLKS - 1)) begin
                level_q <= sync_b;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end else begin
            run_q <= '0;
        end
    end

    assign clean_out = level_q;

endmodule

// File: rtl/abc_spi_reader.sv
module abc_spi_reader
    import abc_pkg::*;
#(
    parameter int HALF_CLKS  = 4,
    parameter int FRAME_BITS = 16,
    parameter int LEAD_BITS  = 3
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    input  logic    miso_raw,
    output logic    cs_n,
    output logic    sclk,
    output logic    valid,
    output sample_t sample
);
    localparam int HW = $clog2(HALF_CLKS + 1);
    localparam int RW = $clog2(FRAME_BITS + 1);

    rd_state_e     state_q;
    spi_pins_t     pins_q;
    logic [HW-1:0] half_q;
    logic [RW-1:0] rises_q;
    logic [1:0]    miso_sync_q;
    sample_t       shift_q;
    sample_t       sample_q;
    logic          valid_q;

    logic toggle_now;
    logic rising_now;

    assign toggle_now = (state_q == RD_SHIFT) && (half_q == HW'(HALF_CLKS - 1));
    assign rising_now = toggle_now && !pins_q.sclk;

    always_ff @(posedge clk) begin
        miso_sync_q <= {miso_sync_q[0], miso_raw};
        if (rst) begin
            state_q  <= RD_IDLE;
            pins_q   <= '{cs_n: 1'b1, sclk: 1'b1};
            half_q   <= '0;
            rises_q  <= '0;
            shift_q  <= '0;
            sample_q <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            case (state_q)
                RD_IDLE: begin
                    if (start) begin
                        state_q     <= RD_SHIFT;
                        pins_q.cs_n <= 1'b0;
                        half_q      <= '0;
                        rises_q     <= '0;
                    end
                end
                RD_SHIFT: begin
                    if (toggle_now) begin
                        half_q      <= '0;
                        pins_q.sclk <= ~pins_q.sclk;
                        if (rising_now) begin
                            rises_q <= rises_q + 1'b1;
                            if (in_window(int'(rises_q), LEAD_BITS))
                                shift_q <= {shift_q[SAMPLE_W-2:0], miso_sync_q[1]};
                            if (rises_q == RW'(FRAME_BITS - 1)) begin
                                state_q     <= RD_IDLE;
                                pins_q.cs_n <= 1'b1;
                                valid_q     <= 1'b1;
                                sample_q    <= shift_q;
                            end
                        end
                    end else begin
                        half_q <= half_q + 1'b1;
                    end
                end
                default: state_q <= RD_IDLE;
            endcase
        end
    end

    assign cs_n   = pins_q.cs_n;
    assign sclk   = pins_q.sclk;
    assign valid  = valid_q;
    assign sample = sample_q;

    // R4: the serial clock rests high whenever the sensor is deselected
    assert_sclk_idle_high_R4: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> sclk);

    // R6: completion is a single-cycle pulse
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        valid |=> !valid);

    // R6: completion coincides with chip select returning high
    assert_valid_at_frame_end_R6: assert property (@(posedge clk) disable iff (rst)
        valid |-> $rose(cs_n));

endmodule

// File: rtl/abc_pwm.sv
module abc_pwm
    import abc_pkg::*;
#(
    parameter int PRESCALE = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  sample_t duty,
    output logic    pwm_out
);
    localparam int PW = $clog2(PRESCALE + 1);

    logic [PW-1:0] pre_q;
    sample_t       step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            step_q <= '0;
        end else if (pre_q == PW'(PRESCALE - 1)) begin
            pre_q  <= '0;
            step_q <= step_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    assign pwm_out = step_q < duty;

    // R7: the step counter never jumps, it only holds or advances by one
    assert_step_increments_R7: assert property (@(posedge clk) disable iff (rst)
        (step_q != $past(step_q)) |-> (step_q == sample_t'($past(step_q) + 1'b1)));

endmodule

// File: rtl/auto_bright_ctrl.sv
module auto_bright_ctrl
    import abc_pkg::*;
#(
    parameter int DEBOUNCE_CLKS = 8,
    parameter int REQ_PERIOD    = 700,
    parameter int HALF_CLKS     = 4,
    parameter int FRAME_BITS    = 16,
    parameter int LEAD_BITS     = 3,
    parameter int PWM_PRESCALE  = 2
) (
    input  logic clk,
    input  logic rst_sw,
    output logic spi_cs_n,
    output logic spi_sclk,
    input  logic spi_miso,
    output logic led_out
);
    localparam int RQW = $clog2(REQ_PERIOD + 1);

    logic           rst_core;
    logic [RQW-1:0] req_cnt_q;
    logic           req_q;
    logic           rd_valid;
    sample_t        rd_sample;
    sample_t        duty_q;

    abc_debounce #(.STABLE_CLKS(DEBOUNCE_CLKS)) u_debounce (
        .clk      (clk),
        .raw_in   (rst_sw),
        .clean_out(rst_core)
    );

    // Periodic read request
    always_ff @(posedge clk) begin
        if (rst_core) begin
            req_cnt_q <= '0;
            req_q     <= 1'b0;
        end else if (req_cnt_q == RQW'(REQ_PERIOD - 1)) begin
            req_cnt_q <= '0;
            req_q     <= 1'b1;
        end else begin
            req_cnt_q <= req_cnt_q + 1'b1;
            req_q     <= 1'b0;
        end
    end

    abc_spi_reader #(
        .HALF_CLKS (HALF_CLKS),
        .FRAME_BITS(FRAME_BITS),
        .LEAD_BITS (LEAD_BITS)
    ) u_reader (
        .clk     (clk),
        .rst     (rst_core),
        .start   (req_q),
        .miso_raw(spi_miso),
        .cs_n    (spi_cs_n),
        .sclk    (spi_sclk),
        .valid   (rd_valid),
        .sample  (rd_sample)
    );

    // Duty setting follows each completed light reading
    always_ff @(posedge clk) begin
        if (rst_core)      duty_q <= '0;
        else if (rd_valid) duty_q <= rd_sample;
    end

    abc_pwm #(.PRESCALE(PWM_PRESCALE)) u_pwm (
        .clk    (clk),
        .rst    (rst_core),
        .duty   (duty_q),
        .pwm_out(led_out)
    );

    // R3: a request is a one-cycle pulse
    assert_req_pulse_R3: assert property (@(posedge clk) disable iff (rst_core)
        req_q |=> !req_q);

    // R3: a frame starts only in answer to a request
    assert_frame_on_request_R3: assert property (@(posedge clk) disable iff (rst_core)
        $fell(spi_cs_n) |-> $past(req_q));

    // R6: duty holds unless a reading has just completed
    assert_duty_hold_R6: assert property (@(posedge clk) disable iff (rst_core)
        !rd_valid |=> $stable(duty_q));

endmodule

// File: tb/auto_bright_ctrl_bench.sv
`timescale 1ns/1ps
module auto_bright_ctrl_bench;
    localparam int DB    = 8;
    localparam int P     = 700;
    localparam int H     = 4;
    localparam int FB    = 16;
    localparam int LEAD  = 3;
    localparam int PS    = 2;
    localparam int FRAME = 2 * H * FB;

    logic clk = 1'b0;
    logic sw;
    logic miso;
    logic spi_cs_n, spi_sclk, led_out;

    always #10 clk = ~clk;

    auto_bright_ctrl #(
        .DEBOUNCE_CLKS(DB), .REQ_PERIOD(P), .HALF_CLKS(H),
        .FRAME_BITS(FB), .LEAD_BITS(LEAD), .PWM_PRESCALE(PS)
    ) u_auto_bright_ctrl (
        .clk(clk), .rst_sw(sw), .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk),
        .spi_miso(miso), .led_out(led_out)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- sensor model ----------------
    logic [7:0] levels [6] = '{8'hFF, 8'h00, 8'h80, 8'h01, 8'hC3, 8'h3C};
    int frame_idx = 0;
    int fall_cnt  = 0;
    int last_sent = 0;

    function automatic logic sensor_bit(input int idx, input int pos);
        logic [7:0] v;
        v = levels[idx % 6];
        if (pos >= LEAD && pos < LEAD + 8) return v[7 - (pos - LEAD)];
        return idx[0];   // odd frames put ones on the non-data positions (R5)
    endfunction

    initial miso = 1'b0;

    always @(negedge spi_cs_n) begin
        frame_idx++;
        fall_cnt  = 0;
        last_sent = int'(levels[frame_idx % 6]);
    end

    always @(posedge spi_cs_n) begin
        #1 miso = 1'b0;
    end

    always @(negedge spi_sclk) begin
        if (!spi_cs_n) begin
            #1 miso = sensor_bit(frame_idx, fall_cnt);
            fall_cnt++;
        end
    end

    // ---------------- reference model ----------------
    bit model_on = 0;
    bit s1, s2, db, rst_old, m_rst;
    int dbc, k, pc, step, duty, n, off;
    bit exp_cs, exp_sclk, exp_led;
    bit meas_on = 0;
    int meas_cnt, meas_hi;

    always @(posedge clk) begin
        if (model_on) begin
            rst_old = db;
            if (s2 != db) begin
                if (dbc == DB - 1) begin db = s2; dbc = 0; end
                else dbc++;
            end else dbc = 0;
            s2 = s1;
            s1 = sw;
            m_rst = rst_old;
            if (rst_old) begin
                k = 0; pc = 0; step = 0; duty = 0; meas_on = 0;
                exp_cs = 1; exp_sclk = 1;
            end else begin
                k++;
                if (pc == PS - 1) begin pc = 0; step = (step + 1) % 256; end
                else pc++;
                n   = (k - 1) / P;
                off = (k - 1) % P;
                if (n >= 1 && off == FRAME + 1) begin
                    duty = last_sent; meas_on = 1; meas_cnt = 0; meas_hi = 0;
                end
                if (n >= 1 && off < FRAME) begin
                    exp_cs   = 0;
                    exp_sclk = ((off / H) % 2 == 0);
                end else begin
                    exp_cs = 1; exp_sclk = 1;
                end
            end
            exp_led = (step < duty);
        end
    end

    always @(negedge clk) begin
        if (model_on && !done) begin
            check(spi_cs_n == exp_cs, m_rst ? "R2 spi_cs_n" : "R3/R4 spi_cs_n", spi_cs_n, exp_cs);
            check(spi_sclk == exp_sclk, m_rst ? "R2 spi_sclk" : "R4 spi_sclk", spi_sclk, exp_sclk);
            check(led_out == exp_led, m_rst ? "R2 led_out" : "R6/R7 led_out", led_out, exp_led);
            if (meas_on) begin
                meas_hi += int'(led_out);
                meas_cnt++;
                if (meas_cnt == 256 * PS) begin
                    check(meas_hi == duty * PS, "R5/R7 on-time per period", meas_hi, duty * PS);
                    meas_on = 0;
                end
            end
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        sw = 1'b1;
        repeat (64) @(negedge clk);
        s1 = 1; s2 = 1; db = 1; dbc = 0; m_rst = 1;
        k = 0; pc = 0; step = 0; duty = 0;
        exp_cs = 1; exp_sclk = 1; exp_led = 0;
        check(spi_cs_n == 1 && spi_sclk == 1 && led_out == 0, "R2 reset state",
              {spi_cs_n, spi_sclk, led_out}, 3'b110);
        model_on = 1;

        @(negedge clk) sw = 1'b0;
        repeat (7 * P) @(negedge clk);

        // R1: a press one edge short of the window must not reset
        sw = 1'b1;
        repeat (DB - 1) @(negedge clk);
        sw = 1'b0;
        do @(negedge clk); while (exp_cs != 0);
        check(spi_cs_n == 0, "R1 frame still issued after short glitch", spi_cs_n, 0);
        repeat (2 * P) @(negedge clk);

        // R1: a press held for the full window resets the block
        sw = 1'b1;
        repeat (DB + 6) @(negedge clk);
        check(spi_cs_n == 1 && led_out == 0, "R1 reset after held press",
              {spi_cs_n, led_out}, 2'b10);
        repeat (20) @(negedge clk);
        sw = 1'b0;
        repeat (2 * P) @(negedge clk);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule